// File: doc/BRIEF.md
# Mode-Configurable Distributed Single-Port RAM

This block is a small memory of the kind built from logic-cell lookup tables. It holds two banks of 16 one-bit cells, F and G. The `mode_i` input sets how the banks are used. In narrow mode (`mode_i`=0) the block is a 16-word by 2-bit memory: each bank has its own address and its own data bit. In wide mode (`mode_i`=1) it is a 32-word by 1-bit memory: `d1_i` becomes the top address bit and picks the bank, and both banks share `addr_f_i`.

Writes are synchronous. A single active clock edge samples the address, the data and `we_i` together, so `we_i` works as a plain clock enable. A parameter chooses whether that edge is the rising or the falling one, and the choice covers both banks. Reads are combinational from the present address. A third output combines the two bank outputs, with `d1_i` as the select. In wide mode this output is the 32-word read port.

An output register stage can be left out, or it can sample on the write edge or on the opposite edge. Every cell comes out of reset holding its value from the `INIT_F` and `INIT_G` parameters.

Top module: `cfg_lut_ram`

## Requirements
- R1: While `rst_ni` is low, every F cell equals the matching bit of `INIT_F`, every G cell equals the matching bit of `INIT_G`, and the registered outputs are 0 when the output register is present.
- R2: Narrow mode (`mode_i`=0) with `we_i`=1 at the write edge: F[`addr_f_i`] takes `d0_i` and G[`addr_g_i`] takes `d1_i`.
- R3: With `we_i`=0 at the write edge, no cell changes.
- R4: Wide mode (`mode_i`=1) with `we_i`=1: `d0_i` is written to F[`addr_f_i`] when `d1_i`=0, or to G[`addr_f_i`] when `d1_i`=1. The other bank is left unchanged and `addr_g_i` is ignored.
- R5: Reads need no clock. `f_o`=F[`addr_f_i`]. `g_o`=G[`addr_g_i`] in narrow mode and G[`addr_f_i`] in wide mode. Data written at an edge is visible straight after that edge.
- R6: `h_o` equals `g_o` when `d1_i`=1 and `f_o` when `d1_i`=0. In wide mode this makes `h_o` the 32-word read at address {`d1_i`,`addr_f_i`}.
- R7: Parameter `WR_FALL`=0 writes on the rising edge of `clk_i` and `WR_FALL`=1 writes on the falling edge. The other edge never changes a cell.
- R8: `OREG_MODE` sets the output register. With 0, {`f_q_o`,`g_q_o`,`h_q_o`} follow {`f_o`,`g_o`,`h_o`} directly. With 1, they capture on the write edge and hold the values from before that edge's write. With 2, they capture on the opposite edge.
- R9: Bit i of `INIT_F` or `INIT_G` is the initial content of word i of bank F or G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; active write edge set by `WR_FALL` |
| rst_ni | input | 1 | Asynchronous active-low reset to the initial contents |
| mode_i | input | 1 | 0: 16x2 narrow mode, 1: 32x1 wide mode |
| addr_f_i | input | AW | Address of bank F; shared address in wide mode |
| addr_g_i | input | AW | Address of bank G in narrow mode |
| d0_i | input | 1 | Data for bank F (narrow) or the single data bit (wide) |
| d1_i | input | 1 | Data for bank G (narrow) or the top address bit (wide); select of `h_o` |
| we_i | input | 1 | Active-high write enable sampled on the write edge |
| f_o | output | 1 | Combinational read of bank F |
| g_o | output | 1 | Combinational read of bank G |
| h_o | output | 1 | Combined read, `d1_i` selects G over F |
| f_q_o | output | 1 | Registered or bypassed `f_o` |
| g_q_o | output | 1 | Registered or bypassed `g_o` |
| h_q_o | output | 1 | Registered or bypassed `h_o` |

## Verification
A wrong cell stays hidden until its address is read. It then shows on `f_o`, `g_o` or `h_o` in the same cycle and on the registered outputs at the next capture edge. For that reason the bench reads back across all addresses after each phase of writes, in addition to comparing every cycle. A fault in wide-mode bank selection or in write-edge polarity shows as a mismatch on the first later read of the affected word. Three instances with different edge and register settings make a polarity fault show up as a half-cycle early or late update.

// File: rtl/cfg_lut_ram_pkg.sv
package cfg_lut_ram_pkg;
  typedef enum logic {
    MODE_16X2 = 1'b0,
    MODE_32X1 = 1'b1
  } ram_mode_e;

  localparam int OREG_NONE = 0;
  localparam int OREG_SAME = 1;
  localparam int OREG_OPP  = 2;
endpackage

// File: rtl/cfg_lut_ram_route.sv
module cfg_lut_ram_route
  import cfg_lut_ram_pkg::*;
#(
  parameter int AW = 4
) (
  input  ram_mode_e        mode_i,
  input  logic [AW-1:0]    addr_f_i,
  input  logic [AW-1:0]    addr_g_i,
  input  logic             d0_i,
  input  logic             d1_i,
  input  logic             we_i,
  output logic             we_f_o,
  output logic             we_g_o,
  output logic [AW-1:0]    wa_f_o,
  output logic [AW-1:0]    wa_g_o,
  output logic             wd_f_o,
  output logic             wd_g_o,
  output logic [AW-1:0]    ra_f_o,
  output logic [AW-1:0]    ra_g_o
);
  logic wide;
  assign wide = (mode_i == MODE_32X1);

  // in wide mode d1 is the bank select (top address bit)
  assign we_f_o = we_i & (~wide | ~d1_i);
  assign we_g_o = we_i & (~wide |  d1_i);
  assign wa_f_o = addr_f_i;
  assign wa_g_o = wide ? addr_f_i : addr_g_i;
  assign wd_f_o = d0_i;
  assign wd_g_o = wide ? d0_i : d1_i;
  assign ra_f_o = addr_f_i;
  assign ra_g_o = wide ? addr_f_i : addr_g_i;
endmodule

// File: rtl/cfg_lut_ram_half.sv
module cfg_lut_ram_half #(
  parameter int                 AW      = 4,
  parameter bit                 WR_FALL = 1'b0,
  parameter logic [(1<<AW)-1:0] INIT    = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic                  wdata_i,
  input  logic [AW-1:0]         raddr_i,
  output logic                  rdata_o,
  output logic [(1<<AW)-1:0]    bits_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] cells_q, cells_d;

  always_comb begin
    cells_d = cells_q;
    if (we_i) cells_d[waddr_i] = wdata_i;
  end

  if (WR_FALL) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cells_q <= INIT;
      else         cells_q <= cells_d;
    end
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cells_q <= INIT;
      else         cells_q <= cells_d;
    end
  end

  assign rdata_o = cells_q[raddr_i];
  assign bits_o  = cells_q;
endmodule

// File: rtl/cfg_lut_ram_oreg.sv
module cfg_lut_ram_oreg #(
  parameter int W         = 3,
  parameter int OREG_MODE = 1,
  parameter bit CAP_FALL  = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OREG_MODE == 0) begin : g_bypass
    assign q_o = d_i;
  end else if (CAP_FALL) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end
endmodule

// File: rtl/cfg_lut_ram.sv
module cfg_lut_ram
  import cfg_lut_ram_pkg::*;
#(
  parameter int                 AW        = 4,
  parameter bit                 WR_FALL   = 1'b0,
  parameter int                 OREG_MODE = OREG_SAME,
  parameter logic [(1<<AW)-1:0] INIT_F    = '0,
  parameter logic [(1<<AW)-1:0] INIT_G    = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_f_i,
  input  logic [AW-1:0] addr_g_i,
  input  logic          d0_i,
  input  logic          d1_i,
  input  logic          we_i,
  output logic          f_o,
  output logic          g_o,
  output logic          h_o,
  output logic          f_q_o,
  output logic          g_q_o,
  output logic          h_q_o
);
  localparam int DEPTH    = 1 << AW;
  localparam bit REG_FALL = (OREG_MODE == OREG_OPP) ? !WR_FALL : WR_FALL;

  logic             we_f, we_g, wd_f, wd_g;
  logic [AW-1:0]    wa_f, wa_g, ra_f, ra_g;
  logic [DEPTH-1:0] bits_f, bits_g;

  cfg_lut_ram_route #(.AW(AW)) u_route (
    .mode_i   (ram_mode_e'(mode_i)),
    .addr_f_i (addr_f_i),
    .addr_g_i (addr_g_i),
    .d0_i     (d0_i),
    .d1_i     (d1_i),
    .we_i     (we_i),
    .we_f_o   (we_f),
    .we_g_o   (we_g),
    .wa_f_o   (wa_f),
    .wa_g_o   (wa_g),
    .wd_f_o   (wd_f),
    .wd_g_o   (wd_g),
    .ra_f_o   (ra_f),
    .ra_g_o   (ra_g)
  );

  cfg_lut_ram_half #(.AW(AW), .WR_FALL(WR_FALL), .INIT(INIT_F)) u_bank_f (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_f),
    .waddr_i (wa_f),
    .wdata_i (wd_f),
    .raddr_i (ra_f),
    .rdata_o (f_o),
    .bits_o  (bits_f)
  );

  cfg_lut_ram_half #(.AW(AW), .WR_FALL(WR_FALL), .INIT(INIT_G)) u_bank_g (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_g),
    .waddr_i (wa_g),
    .wdata_i (wd_g),
    .raddr_i (ra_g),
    .rdata_o (g_o),
    .bits_o  (bits_g)
  );

  // combining stage: 2:1 mux, in wide mode the 32-word read
  assign h_o = d1_i ? g_o : f_o;

  cfg_lut_ram_oreg #(.W(3), .OREG_MODE(OREG_MODE), .CAP_FALL(REG_FALL)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({f_o, g_o, h_o}),
    .q_o    ({f_q_o, g_q_o, h_q_o})
  );
endmodule

// File: rtl/cfg_lut_ram_chk.sv
module cfg_lut_ram_chk #(
  parameter int                 AW        = 4,
  parameter bit                 WR_FALL   = 1'b0,
  parameter int                 OREG_MODE = 1,
  parameter logic [(1<<AW)-1:0] INIT_F    = '0,
  parameter logic [(1<<AW)-1:0] INIT_G    = '0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 mode_i,
  input logic [AW-1:0]        addr_f_i,
  input logic [AW-1:0]        addr_g_i,
  input logic                 d0_i,
  input logic                 d1_i,
  input logic                 we_i,
  input logic                 f_o,
  input logic                 g_o,
  input logic                 h_o,
  input logic                 f_q_o,
  input logic                 g_q_o,
  input logic                 h_q_o,
  input logic [(1<<AW)-1:0]   bits_f,
  input logic [(1<<AW)-1:0]   bits_g
);
  localparam int DEPTH    = 1 << AW;
  localparam bit REG_FALL = (OREG_MODE == 2) ? !WR_FALL : WR_FALL;

  logic wclk, rclk;
  assign wclk = clk_i ^ WR_FALL;
  assign rclk = clk_i ^ REG_FALL;

  logic [2*DEPTH-1:0] snap;
  logic               snap_ok;
  always_ff @(negedge wclk or negedge rst_ni) begin
    if (!rst_ni) begin
      snap    <= '0;
      snap_ok <= 1'b0;
    end else begin
      snap    <= {bits_f, bits_g};
      snap_ok <= 1'b1;
    end
  end

  p_init_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (bits_f == INIT_F) && (bits_g == INIT_G) &&
                (OREG_MODE == 0 || {f_q_o, g_q_o, h_q_o} == 3'b000));

  p_wr_f_r2: assert property (@(posedge wclk) disable iff (!rst_ni)
    we_i && !mode_i |=> bits_f[$past(addr_f_i)] == $past(d0_i));

  p_wr_g_r2: assert property (@(posedge wclk) disable iff (!rst_ni)
    we_i && !mode_i |=> bits_g[$past(addr_g_i)] == $past(d1_i));

  p_hold_r3: assert property (@(posedge wclk) disable iff (!rst_ni)
    !we_i |=> $stable(bits_f) && $stable(bits_g));

  p_lo_bank_r4: assert property (@(posedge wclk) disable iff (!rst_ni)
    we_i && mode_i && !d1_i |=> $stable(bits_g) && bits_f[$past(addr_f_i)] == $past(d0_i));

  p_hi_bank_r4: assert property (@(posedge wclk) disable iff (!rst_ni)
    we_i && mode_i && d1_i |=> $stable(bits_f) && bits_g[$past(addr_f_i)] == $past(d0_i));

  p_rd_f_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> f_o == bits_f[addr_f_i]);

  p_rd_g_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> g_o == (mode_i ? bits_g[addr_f_i] : bits_g[addr_g_i]));

  p_idle_edge_r7: assert property (@(posedge wclk) disable iff (!rst_ni)
    snap_ok |-> {bits_f, bits_g} == snap);

  if (OREG_MODE != 0) begin : g_oreg_chk
    p_oreg_r8: assert property (@(posedge rclk) disable iff (!rst_ni)
      rst_ni |=> {f_q_o, g_q_o, h_q_o} == $past({f_o, g_o, h_o}));
  end
endmodule

bind cfg_lut_ram cfg_lut_ram_chk #(
  .AW(AW), .WR_FALL(WR_FALL), .OREG_MODE(OREG_MODE), .INIT_F(INIT_F), .INIT_G(INIT_G)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .addr_f_i(addr_f_i),
  .addr_g_i(addr_g_i), .d0_i(d0_i), .d1_i(d1_i), .we_i(we_i),
  .f_o(f_o), .g_o(g_o), .h_o(h_o), .f_q_o(f_q_o), .g_q_o(g_q_o), .h_q_o(h_q_o),
  .bits_f(bits_f), .bits_g(bits_g)
);

// File: tb/cfg_lut_ram_tb.sv
`timescale 1ns/1ps
module cfg_lut_ram_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       mode_i = 1'b0;
  logic [3:0] addr_f_i = '0, addr_g_i = '0;
  logic       d0_i = 1'b0, d1_i = 1'b0, we_i = 1'b0;
  logic [2:0] f_w, g_w, h_w, fq_w, gq_w, hq_w;

  int    runs = 0, fails = 0;
  bit    done = 1'b0;
  string phase = "R1";
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk_i = ~clk_i;

  // instance 0: rising write, register on opposite (falling) edge
  cfg_lut_ram #(.AW(4), .WR_FALL(1'b0), .OREG_MODE(2), .INIT_F(16'hA5C3), .INIT_G(16'h0FF0)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .addr_f_i(addr_f_i), .addr_g_i(addr_g_i),
    .d0_i(d0_i), .d1_i(d1_i), .we_i(we_i), .f_o(f_w[0]), .g_o(g_w[0]), .h_o(h_w[0]),
    .f_q_o(fq_w[0]), .g_q_o(gq_w[0]), .h_q_o(hq_w[0]));
  // instance 1: falling write, register on the same (falling) edge
  cfg_lut_ram #(.AW(4), .WR_FALL(1'b1), .OREG_MODE(1), .INIT_F(16'h1234), .INIT_G(16'hFEDC)) dut_b_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .addr_f_i(addr_f_i), .addr_g_i(addr_g_i),
    .d0_i(d0_i), .d1_i(d1_i), .we_i(we_i), .f_o(f_w[1]), .g_o(g_w[1]), .h_o(h_w[1]),
    .f_q_o(fq_w[1]), .g_q_o(gq_w[1]), .h_q_o(hq_w[1]));
  // instance 2: rising write, no output register
  cfg_lut_ram #(.AW(4), .WR_FALL(1'b0), .OREG_MODE(0), .INIT_F(16'h8001), .INIT_G(16'h7FFE)) dut_c_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .addr_f_i(addr_f_i), .addr_g_i(addr_g_i),
    .d0_i(d0_i), .d1_i(d1_i), .we_i(we_i), .f_o(f_w[2]), .g_o(g_w[2]), .h_o(h_w[2]),
    .f_q_o(fq_w[2]), .g_q_o(gq_w[2]), .h_q_o(hq_w[2]));

  // behavioural reference: one 32-entry array per instance, index {bank, addr}
  bit [15:0] init_f [3] = '{16'hA5C3, 16'h1234, 16'h8001};
  bit [15:0] init_g [3] = '{16'h0FF0, 16'hFEDC, 16'h7FFE};
  bit        ref_mem [3][32];
  bit [2:0]  ref_q   [3];

  function automatic bit [2:0] ref_read(int k);
    bit f, g, h;
    f = ref_mem[k][{1'b0, addr_f_i}];
    g = mode_i ? ref_mem[k][{1'b1, addr_f_i}] : ref_mem[k][{1'b1, addr_g_i}];
    h = d1_i ? g : f;
    return {f, g, h};
  endfunction

  task automatic ref_write(int k);
    if (we_i) begin
      if (!mode_i) begin
        ref_mem[k][{1'b0, addr_f_i}] = d0_i;
        ref_mem[k][{1'b1, addr_g_i}] = d1_i;
      end else begin
        ref_mem[k][{d1_i, addr_f_i}] = d0_i;
      end
    end
  endtask

  always @(negedge rst_ni) begin
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 16; i++) begin
        ref_mem[k][i]      = init_f[k][i];
        ref_mem[k][16 + i] = init_g[k][i];
      end
      ref_q[k] = 3'b000;
    end
  end

  always @(posedge clk_i) if (rst_ni) begin
    ref_write(0);
    ref_write(2);
  end

  always @(negedge clk_i) if (rst_ni) begin
    ref_q[0] = ref_read(0);
    ref_q[1] = ref_read(1);  // same edge: captured before this edge's write
    ref_write(1);
  end

  task automatic chk(int k, string tag, logic got, bit exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s dut%0d @%0t: got %b expected %b", phase, tag, k, $time, got, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 3; k++) begin
      bit [2:0] c, q;
      c = ref_read(k);
      q = (k == 2) ? c : ref_q[k];
      chk(k, "R5 f_o", f_w[k], c[2]);
      chk(k, "R5 g_o", g_w[k], c[1]);
      chk(k, "R6 h_o", h_w[k], c[0]);
      chk(k, "R8 f_q_o", fq_w[k], q[2]);
      chk(k, "R8 g_q_o", gq_w[k], q[1]);
      chk(k, "R8 h_q_o", hq_w[k], q[0]);
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // inputs change 2 ns after the rising edge; compare 8 ns after it
  task automatic step(bit m, logic [3:0] a, logic [3:0] b, bit x0, bit x1, bit w);
    @(posedge clk_i);
    #2;
    mode_i = m; addr_f_i = a; addr_g_i = b; d0_i = x0; d1_i = x1; we_i = w;
    #6;
    check_all();
  endtask

  task automatic rnd_step(int m_sel, int w_sel);
    bit m, w;
    lfsr = nxt(lfsr);
    m = (m_sel == 2) ? lfsr[20] : m_sel[0];
    w = (w_sel == 2) ? lfsr[21] : w_sel[0];
    step(m, lfsr[3:0], lfsr[7:4], lfsr[8], lfsr[9], w);
  endtask

  task automatic sweep();
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 4'(i), 4'(15 - i), 1'b0, 1'b0, 1'b0);
      step(1'b1, 4'(i), 4'(i), 1'b1, 1'b0, 1'b0);
      step(1'b1, 4'(i), 4'(i), 1'b0, 1'b1, 1'b0);
    end
  endtask

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    phase = "R1";
    step(1'b0, 4'h3, 4'h5, 1'b1, 1'b1, 1'b1);    // write attempt under reset
    step(1'b1, 4'h9, 4'h2, 1'b1, 1'b1, 1'b1);
    @(posedge clk_i); #2 rst_ni = 1'b1;
    phase = "R9";
    sweep();
    phase = "R2";
    for (int i = 0; i < 60; i++) rnd_step(0, 1);
    phase = "R3";
    for (int i = 0; i < 40; i++) rnd_step(0, 0);
    for (int i = 0; i < 30; i++) rnd_step(1, 0);
    sweep();
    phase = "R4";
    for (int i = 0; i < 80; i++) rnd_step(1, 2);
    sweep();
    phase = "R7";
    for (int i = 0; i < 120; i++) rnd_step(2, 2);
    sweep();
    phase = "R1";
    @(posedge clk_i); #2 rst_ni = 1'b0;
    for (int i = 0; i < 3; i++) rnd_step(2, 1);
    @(posedge clk_i); #2 rst_ni = 1'b1;
    phase = "R9";
    sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule